// File: doc/BRIEF.md
# Staggered Column Power Sequencer

This block drives one analog power-enable line per pixel column so that the analog front-ends are powered only around a particle collision window. A power-on request starts a sequence. The columns are switched on one at a time, in index order, with a configurable number of clock cycles between them, so the supply sees a series of small current steps instead of one large step.

After the last column is on, the block waits a configurable settling time and then raises a front-end ready flag. A shutter request passes through to the array only while that flag is high. The block counts the total time the analog power has been on. When that count reaches a configured maximum, or when the external power-off input is asserted, every column is switched off together in the next cycle. While a sequence is running, a further power-on request does nothing.

The stagger spacing `S`, the settling time `T` and the on-time limit `M` are counted in cycles of `clk`. Each must be at least 1, and each is held stable while a sequence runs.

Top module: `col_pwr_seq`

## Requirements
- R1: While reset is low and after it is released, `col_en` is all zeros, and `fe_ready` and `shutter_out` are both 0.
- R2: When the block is idle, a `pwr_req` sampled high at a clock edge with `pwr_off` low turns on column 0 (bit 0 of `col_en`) at that same edge.
- R3: The columns turn on in ascending index order. Column k turns on exactly k*S cycles after column 0. At most one new column turns on per cycle, and the set of enabled columns is always a contiguous group that starts at bit 0.
- R4: `fe_ready` rises exactly T cycles after the edge at which the highest column was enabled.
- R5: `fe_ready` is high only while every column is enabled.
- R6: Column 0 stays on for at most M cycles. At the M-th edge after it turns on, all enables and `fe_ready` drop together, whatever phase the sequence is in.
- R7: A `pwr_off` sampled high clears every enable and `fe_ready` at that edge. It takes priority over a simultaneous `pwr_req`.
- R8: A `pwr_req` that arrives while any column is enabled is ignored. The ramp timing, the ready time and the on-time limit all stay as they would have been without it.
- R9: `shutter_out` equals `shutter_req` while `fe_ready` is high, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controlling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_req | input | 1 | Power-on request or trigger |
| pwr_off | input | 1 | Forced power-off of every column |
| shutter_req | input | 1 | Requested shutter (acquisition window) |
| cfg_stagger | input | CFG_W | Cycles between successive column enables (S) |
| cfg_settle | input | CFG_W | Settling cycles before ready (T) |
| cfg_max_on | input | CFG_W | Maximum analog on-time in cycles (M) |
| col_en | output | N_COLS | Per-column analog power enable |
| fe_ready | output | 1 | Front-ends powered and settled |
| shutter_out | output | 1 | Shutter passed to the array, gated by ready |

## Verification
The hardest cases to reach are the ones where a second event lands in the middle of a phase. Examples are a power-on request during the ramp or after ready has risen, the on-time limit expiring before the ramp has finished, and a forced power-off during settling. The bench gets there by choosing stagger, settle and limit values whose phase boundaries fall at known cycles. It then places single-cycle pulses on `pwr_req` or `pwr_off` at chosen offsets from the start of the sequence. For each sequence, every expected change of the enables and of ready is queued with its exact cycle. Any change that was not queued is reported.

// File: rtl/col_pwr_seq_pkg.sv
// Package: shared types of the staggered column power sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package col_pwr_seq_pkg;

    // Sequencer phases, visited in this order during a normal cycle
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RAMP   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_ON     = 2'd3
    } seq_state_t;

endpackage

// File: rtl/cps_fsm.sv
// Module: cps_fsm
// Phase controller. It steps OFF -> RAMP -> SETTLE -> ON and issues
// start, advance and clear strobes to the column bank. It also tracks the
// total on-time against the configured limit.
// Assumes: the cfg_* inputs are >= 1 and stable during a sequence.
module cps_fsm
    import col_pwr_seq_pkg::*;
#(
    parameter int N_COLS = 8,
    parameter int CFG_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_req,
    input  logic             pwr_off,
    input  logic [CFG_W-1:0] cfg_stagger,
    input  logic [CFG_W-1:0] cfg_settle,
    input  logic [CFG_W-1:0] cfg_max_on,
    output logic             start_o,
    output logic             advance_o,
    output logic             clear_o,
    output logic             ready_o
);

    localparam int IDX_W = (N_COLS > 1) ? $clog2(N_COLS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_COLS - 1);
    localparam seq_state_t FIRST_PHASE = (N_COLS == 1) ? ST_SETTLE : ST_RAMP;

    seq_state_t       state_q;
    logic [CFG_W-1:0] cnt_q;
    logic [CFG_W-1:0] ontime_q;
    logic [IDX_W-1:0] idx_q;

    logic [CFG_W:0]   cnt_nxt;
    logic [CFG_W:0]   ontime_nxt;
    logic [IDX_W-1:0] idx_nxt;
    logic             stag_hit;
    logic             settle_hit;
    logic             limit_hit;

    // Next-count values and the phase-end comparisons
    always_comb begin
        cnt_nxt    = {1'b0, cnt_q} + 1'b1;
        ontime_nxt = {1'b0, ontime_q} + 1'b1;
        idx_nxt    = idx_q + 1'b1;
        stag_hit   = cnt_nxt >= {1'b0, cfg_stagger};
        settle_hit = cnt_nxt >= {1'b0, cfg_settle};
        limit_hit  = (state_q != ST_OFF) && (ontime_nxt >= {1'b0, cfg_max_on});
    end

    // Strobes to the column bank, and the ready flag
    always_comb begin
        clear_o   = pwr_off || limit_hit;
        start_o   = (state_q == ST_OFF) && pwr_req && !pwr_off;
        advance_o = (state_q == ST_RAMP) && stag_hit && !clear_o;
        ready_o   = (state_q == ST_ON);
    end

    // Phase register and the cycle counters
    always_ff @(posedge clk) begin
        if (!rst_n || clear_o) begin
            state_q  <= ST_OFF;
            cnt_q    <= '0;
            ontime_q <= '0;
            idx_q    <= '0;
        end else begin
            case (state_q)
                ST_OFF: begin
                    if (start_o) begin
                        state_q  <= FIRST_PHASE;
                        cnt_q    <= '0;
                        ontime_q <= '0;
                        idx_q    <= '0;
                    end
                end
                ST_RAMP: begin
                    ontime_q <= ontime_nxt[CFG_W-1:0];
                    if (stag_hit) begin
                        cnt_q <= '0;
                        idx_q <= idx_nxt;
                        if (idx_nxt == LAST_IDX) begin
                            state_q <= ST_SETTLE;
                        end
                    end else begin
                        cnt_q <= cnt_nxt[CFG_W-1:0];
                    end
                end
                ST_SETTLE: begin
                    ontime_q <= ontime_nxt[CFG_W-1:0];
                    if (settle_hit) begin
                        state_q <= ST_ON;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_nxt[CFG_W-1:0];
                    end
                end
                default: begin
                    ontime_q <= ontime_nxt[CFG_W-1:0];
                end
            endcase
        end
    end

endmodule

// File: rtl/cps_col_bank.sv
// Module: cps_col_bank
// One enable flop per column. Start turns on column 0, each advance
// strobe copies column k-1 into column k, and clear drops every column.
// Assumes: the controller issues at most one strobe per cycle, and
// clear has priority.
module cps_col_bank #(
    parameter int N_COLS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              start_i,
    input  logic              advance_i,
    output logic [N_COLS-1:0] col_en_o
);

    logic [N_COLS-1:0] en_q;

    for (genvar k = 0; k < N_COLS; k++) begin : g_col
        if (k == 0) begin : g_first
            // Column 0: set by start, held until clear
            always_ff @(posedge clk) begin
                if (!rst_n || clear_i) begin
                    en_q[k] <= 1'b0;
                end else if (start_i) begin
                    en_q[k] <= 1'b1;
                end
            end
        end else begin : g_rest
            // Column k: copies its lower neighbour on each advance
            always_ff @(posedge clk) begin
                if (!rst_n || clear_i) begin
                    en_q[k] <= 1'b0;
                end else if (advance_i) begin
                    en_q[k] <= en_q[k-1];
                end
            end
        end
    end

    assign col_en_o = en_q;

endmodule

// File: rtl/cps_shutter_gate.sv
// Module: cps_shutter_gate
// Passes the shutter request on only while the front-ends are ready.
// Assumes: ready_i comes from a register, so the gate adds no feedback path.
module cps_shutter_gate (
    input  logic shutter_req_i,
    input  logic ready_i,
    output logic shutter_o
);

    // Refuse the shutter unless the front-ends are ready
    always_comb shutter_o = shutter_req_i && ready_i;

endmodule

// File: rtl/col_pwr_seq.sv
// Module: col_pwr_seq (top)
// Staggered per-column analog power sequencer. A power-on request ramps
// the columns up one by one, waits for settling and then flags ready.
// The on-time limit and the forced power-off both drop every column.
// Assumes: the cfg_* inputs are >= 1 and stable while a sequence runs.
module col_pwr_seq #(
    parameter int N_COLS = 8,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_req,
    input  logic              pwr_off,
    input  logic              shutter_req,
    input  logic [CFG_W-1:0]  cfg_stagger,
    input  logic [CFG_W-1:0]  cfg_settle,
    input  logic [CFG_W-1:0]  cfg_max_on,
    output logic [N_COLS-1:0] col_en,
    output logic              fe_ready,
    output logic              shutter_out
);

    logic start_s;
    logic advance_s;
    logic clear_s;
    logic ready_s;

    cps_fsm #(.N_COLS(N_COLS), .CFG_W(CFG_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_req     (pwr_req),
        .pwr_off     (pwr_off),
        .cfg_stagger (cfg_stagger),
        .cfg_settle  (cfg_settle),
        .cfg_max_on  (cfg_max_on),
        .start_o     (start_s),
        .advance_o   (advance_s),
        .clear_o     (clear_s),
        .ready_o     (ready_s)
    );

    cps_col_bank #(.N_COLS(N_COLS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_s),
        .start_i   (start_s),
        .advance_i (advance_s),
        .col_en_o  (col_en)
    );

    cps_shutter_gate u_gate (
        .shutter_req_i (shutter_req),
        .ready_i       (ready_s),
        .shutter_o     (shutter_out)
    );

    assign fe_ready = ready_s;

endmodule

// File: rtl/cps_checker.sv
// Module: cps_checker
// Property checks on the ports of col_pwr_seq. Bound to every instance.
// Assumes: cfg_max_on is stable while a sequence runs.
module cps_checker #(
    parameter int N_COLS = 8,
    parameter int CFG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_req,
    input logic              pwr_off,
    input logic              shutter_req,
    input logic [CFG_W-1:0]  cfg_max_on,
    input logic [N_COLS-1:0] col_en,
    input logic              fe_ready,
    input logic              shutter_out
);

    logic [CFG_W:0] run_q;

    // Counts consecutive cycles in which column 0 is powered
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else if (col_en[0]) run_q <= run_q + 1'b1;
        else run_q <= '0;
    end

    AST_RST_QUIET: assert property (@(posedge clk) !rst_n |=> (col_en == '0 && !fe_ready)); // R1
    AST_START_COL0: assert property (@(posedge clk) disable iff (!rst_n)
        (col_en == '0 && pwr_req && !pwr_off) |=> col_en[0]); // R2
    AST_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        ((col_en + 1'b1) & col_en) == '0); // R3
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 $countones(col_en & ~$past(col_en)) <= 1); // R3
    AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fe_ready |-> (&col_en)); // R5
    AST_ONTIME_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= {1'b0, cfg_max_on}); // R6
    AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off |=> (col_en == '0 && !fe_ready)); // R7
    AST_SHUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        shutter_out |-> (fe_ready && shutter_req)); // R9

endmodule

bind col_pwr_seq cps_checker #(.N_COLS(N_COLS), .CFG_W(CFG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_req     (pwr_req),
    .pwr_off     (pwr_off),
    .shutter_req (shutter_req),
    .cfg_max_on  (cfg_max_on),
    .col_en      (col_en),
    .fe_ready    (fe_ready),
    .shutter_out (shutter_out)
);

// File: tb/col_pwr_seq_tb.sv
// Scoreboard bench: the driver queues every expected change of
// {col_en, fe_ready} with its cycle; the monitor pops and compares.
module col_pwr_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int CW         = 16;
    localparam int NO_EVENT   = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_req = 1'b0;
    logic          pwr_off = 1'b0;
    logic          shutter_req = 1'b0;
    logic [CW-1:0] cfg_stagger = 16'd1;
    logic [CW-1:0] cfg_settle = 16'd1;
    logic [CW-1:0] cfg_max_on = 16'd1;
    logic [N-1:0]  col_en;
    logic          fe_ready;
    logic          shutter_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    int           q_cyc[$];
    logic [N-1:0] q_en[$];
    logic         q_rdy[$];
    string        q_tag[$];

    logic [N:0]   prev_obs = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    col_pwr_seq #(.N_COLS(N), .CFG_W(CW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_req     (pwr_req),
        .pwr_off     (pwr_off),
        .shutter_req (shutter_req),
        .cfg_stagger (cfg_stagger),
        .cfg_settle  (cfg_settle),
        .cfg_max_on  (cfg_max_on),
        .col_en      (col_en),
        .fe_ready    (fe_ready),
        .shutter_out (shutter_out)
    );

    // Monitor: pops one expected item at each observed output change
    always @(negedge clk) begin
        logic [N:0] cur;
        cur = {col_en, fe_ready};
        if (rst_n && cur !== prev_obs) begin
            n_tests++;
            if (q_cyc.size() == 0) begin
                n_fail++;
                $display("FAIL R8 unexpected change at cycle %0d: actual en=%b rdy=%b expected no change",
                         cyc, col_en, fe_ready);
            end else begin
                int           ec;
                logic [N-1:0] ee;
                logic         er;
                string        et;
                ec = q_cyc.pop_front();
                ee = q_en.pop_front();
                er = q_rdy.pop_front();
                et = q_tag.pop_front();
                if (ec != cyc || ee !== col_en || er !== fe_ready) begin
                    n_fail++;
                    $display("FAIL %s: actual cyc=%0d en=%b rdy=%b expected cyc=%0d en=%b rdy=%b",
                             et, cyc, col_en, fe_ready, ec, ee, er);
                end
            end
        end
        prev_obs <= cur;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Expected enable pattern d cycles after the start edge
    function automatic logic [N-1:0] exp_en(int d, int s, int endd);
        int k;
        if (d >= endd) return '0;
        k = d / s + 1;
        if (k > N) k = N;
        return N'((1 << k) - 1);
    endfunction

    // Driver: queue the expected changes, then play the request, off and shutter stimulus
    task automatic run_seq(input int s, input int t, input int m, input int off_at, input int req_at);
        int   endd;
        int   rd;
        int   base;
        logic [N:0] pv;
        string end_tag;
        endd = (off_at < m) ? off_at : m;
        rd   = (N - 1) * s + t;
        end_tag = (off_at < m) ? "R7 forced off" : ((req_at > 0) ? "R8 limit kept" : "R6 on-time limit");
        @(negedge clk);
        cfg_stagger = CW'(s);
        cfg_settle  = CW'(t);
        cfg_max_on  = CW'(m);
        base = cyc + 1;
        pv = '0;
        for (int d = 0; d <= endd; d++) begin
            logic [N:0] nv;
            nv = {exp_en(d, s, endd), (d >= rd && d < endd)};
            if (nv != pv) begin
                q_cyc.push_back(base + d);
                q_en.push_back(nv[N:1]);
                q_rdy.push_back(nv[0]);
                if (d == endd) q_tag.push_back(end_tag);
                else if (d == 0) q_tag.push_back("R2 column 0 start");
                else if (nv[0]) q_tag.push_back("R4 settle time");
                else q_tag.push_back("R3 stagger step");
            end
            pv = nv;
        end
        pwr_req = 1'b1;
        @(negedge clk);
        for (int d = 0; d <= endd + 2; d++) begin
            shutter_req = d[0];
            #1;
            check("R9 shutter gating", {31'd0, shutter_out},
                  {31'd0, d[0] && d >= rd && d < endd});
            pwr_req = (req_at > 0 && d + 1 == req_at);
            pwr_off = (d + 1 == off_at);
            @(negedge clk);
        end
        pwr_req = 1'b0;
        pwr_off = 1'b0;
        shutter_req = 1'b0;
        @(negedge clk);
        check("R6 queue drained", q_cyc.size(), 0);
        check("R1 idle after sequence", {27'd0, col_en, fe_ready}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset enables", {28'd0, col_en}, 0);
        check("R1 reset ready", {31'd0, fe_ready}, 0);
        shutter_req = 1'b1;
        #1;
        check("R1 reset shutter", {31'd0, shutter_out}, 0);
        shutter_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {27'd0, col_en, fe_ready}, 0);

        run_seq(3, 5, 60, NO_EVENT, 0);   // full sequence, on-time limit in ON
        run_seq(1, 2, 40, NO_EVENT, 20);  // R8 request while ON is ignored
        run_seq(10, 5, 15, NO_EVENT, 5);  // R6 limit during ramp, R8 request during ramp
        run_seq(2, 20, 100, 12, 0);       // R7 forced off during settle
        run_seq(4, 3, 100, 50, 0);        // R7 forced off while ON

        // R7: off takes priority over a simultaneous request while idle
        @(negedge clk);
        pwr_req = 1'b1;
        pwr_off = 1'b1;
        @(negedge clk);
        pwr_req = 1'b0;
        pwr_off = 1'b0;
        check("R7 off beats request", {27'd0, col_en, fe_ready}, 0);
        repeat (3) @(negedge clk);
        check("R7 still idle", {27'd0, col_en, fe_ready}, 0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule